// File: doc/BRIEF.md
# Hysteretic Thermal Trip Guard

This block watches two signed 8-bit temperature channels, one internal and one remote, and decides when the system is critically hot. Each conversion result arrives as a one-cycle strobe tagged with its channel. The reading is compared against that channel's active trip limit. A channel trips only after a run of qualifying readings. It clears only after a second run of readings that sit a fixed hysteresis margin below the limit. The two active-low THERM outputs are driven by the OR of both channel states, so they always move together.

While either channel is tripped, the guard overrides the fan path. The DAC code is forced to full scale and the fan-off request is released. When the trip clears, the fan code register and the fan-run bit come back to the outputs. Any values written to them during the trip are the ones restored.

Two kinds of limit exist. Fixed defaults are used until software sets a write-once lock. After that, the programmable limits take over and can no longer be written until the next reset.

Top module: `therm_guard`

## Requirements
- R1: After reset:
  - both THERM outputs are high;
  - `dac_code` is 0 and `fan_off_n` is 1;
  - `locked` is 0;
  - the programmable limits read back 127 (internal) and 100 (remote).
- R2: A channel trips when three consecutive readings of that channel are strictly greater than its active limit. The THERM outputs go low in the cycle after the third strobe. A reading equal to or below the limit restarts the run. `conv_ready` is always 1, so a strobe is taken every cycle with no back-pressure.
- R3: A tripped channel clears after three consecutive readings that are at or below (active limit − 5). A reading above that threshold restarts the run.
- R4: While unlocked, the active limits are fixed at 70 (internal) and 100 (remote). Writes to `wr_sel` 0 (internal limit) and 1 (remote limit) update the read-back registers but do not change the trip points.
- R5: A write to `wr_sel` 2 with `wr_data[0]`=1 sets `locked`; with bit 0 clear it has no effect. Once set, `locked` stays set until reset. While locked, the programmable limits are active and writes to them are ignored.
- R6: While either channel is tripped, both THERM outputs are low, `dac_code` is 0xFF and `fan_off_n` is 1.
- R7: While no channel is tripped, `dac_code` shows the fan code register (`wr_sel` 3). `fan_off_n` shows the fan-run bit (`wr_sel` 4, bit 0, reset value 1). Both include writes made during a trip.
- R8: `conv_chan` 0 selects the internal channel and 1 the remote channel. Each channel keeps its own qualify count, so readings of the other channel neither add to nor break a run.
- R9: The exit threshold saturates at −128. With an active limit of −125, only a reading of −128 counts toward clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (pin or power-on) |
| conv_valid | input | 1 | Conversion result strobe |
| conv_ready | output | 1 | Always 1; results are never stalled |
| conv_chan | input | 1 | Channel of the result: 0 internal, 1 remote |
| conv_temp | input | 8 | Reading, two's complement degrees |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 int limit, 1 rem limit, 2 lock, 3 fan code, 4 fan-run bit |
| wr_data | input | 8 | Write data |
| therm_a_n | output | 1 | Over-temperature, active low |
| therm_b_n | output | 1 | Second copy of the over-temperature output |
| dac_code | output | 8 | Fan DAC code after override |
| fan_off_n | output | 1 | Fan-off request, active low |
| locked | output | 1 | Write-once lock state |
| lim_int_q | output | 8 | Programmable internal limit read-back |
| lim_rem_q | output | 8 | Programmable remote limit read-back |

## Verification
A qualify counter that has drifted shows up as THERM moving one strobe early or late. The bench sees it in the cycle after the offending strobe, because every reading is followed by a port check. A wrong lock state or a wrong limit selection shifts the trip point, which the full sweep of readings across each limit exposes at the exact boundary value. A lost fan code or fan-run bit appears on `dac_code` or `fan_off_n` in the first cycle after a trip clears.

// File: rtl/therm_guard_pkg.sv
package therm_guard_pkg;
  localparam int NCH    = 2;
  localparam int CH_INT = 0;
  localparam int CH_REM = 1;

  typedef enum logic [2:0] {
    SEL_LIM_INT  = 3'd0,
    SEL_LIM_REM  = 3'd1,
    SEL_LOCK     = 3'd2,
    SEL_FAN_CODE = 3'd3,
    SEL_FAN_RUN  = 3'd4
  } wr_sel_e;
endpackage

// File: rtl/tg_trip_chan.sv
module tg_trip_chan #(
  parameter int DATA_W = 8,
  parameter int QUAL_N = 3,
  parameter int HYST   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_vld,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [DATA_W-1:0] limit,
  output logic                     tripped
);
  localparam int CNT_W = $clog2(QUAL_N + 1);
  localparam logic signed [DATA_W:0] HYST_S  = HYST;
  localparam logic signed [DATA_W:0] FLOOR_S = -(2 ** (DATA_W - 1));

  logic signed [DATA_W:0] sample_w, limit_w, thr_raw, exit_thr;
  logic                   hot, cool, qualify;
  logic [CNT_W-1:0]       run_cnt;

  // Widen by one bit so the margin subtraction cannot wrap.
  always_comb begin
    sample_w = sample;
    limit_w  = limit;
    thr_raw  = limit_w - HYST_S;
    exit_thr = (thr_raw < FLOOR_S) ? FLOOR_S : thr_raw;
    hot      = sample > limit;
    cool     = sample_w <= exit_thr;
    qualify  = tripped ? cool : hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      tripped <= 1'b0;
    end else if (sample_vld) begin
      if (!qualify) begin
        run_cnt <= '0;
      end else if (run_cnt == CNT_W'(QUAL_N - 1)) begin
        run_cnt <= '0;
        tripped <= ~tripped;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tg_limit_regs.sv
module tg_limit_regs import therm_guard_pkg::*; #(
  parameter int                       DATA_W   = 8,
  parameter int                       NLIM     = 2,
  parameter logic [NLIM*DATA_W-1:0]   DEF_LIMS = '0,
  parameter logic [NLIM*DATA_W-1:0]   RST_LIMS = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [2:0]               wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     locked,
  output logic [NLIM*DATA_W-1:0]   prog_lims,
  output logic [NLIM*DATA_W-1:0]   act_lims
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        locked <= 1'b0;
    else if (wr_en && wr_sel == SEL_LOCK && wr_data[0]) locked <= 1'b1;
  end

  // Limit for channel g lives at select value g.
  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prog_lims[g*DATA_W +: DATA_W] <= RST_LIMS[g*DATA_W +: DATA_W];
      else if (wr_en && !locked && wr_sel == 3'(g))
        prog_lims[g*DATA_W +: DATA_W] <= wr_data;
    end
  end

  assign act_lims = locked ? prog_lims : DEF_LIMS;
endmodule

// File: rtl/tg_fan_override.sv
module tg_fan_override import therm_guard_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trip,
  output logic [DATA_W-1:0] dac_code,
  output logic              fan_off_n
);
  logic [DATA_W-1:0] code_q;
  logic              run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      run_q  <= 1'b1;
    end else if (wr_en) begin
      if (wr_sel == SEL_FAN_CODE) code_q <= wr_data;
      if (wr_sel == SEL_FAN_RUN)  run_q  <= wr_data[0];
    end
  end

  // Registers keep tracking writes; the trip only masks them.
  assign dac_code  = trip ? '1 : code_q;
  assign fan_off_n = trip | run_q;
endmodule

// File: rtl/therm_guard.sv
module therm_guard import therm_guard_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int QUAL_N      = 3,
  parameter int HYST        = 5,
  parameter int DEF_LIM_INT = 70,
  parameter int DEF_LIM_REM = 100,
  parameter int RST_LIM_INT = 127,
  parameter int RST_LIM_REM = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic              conv_chan,
  input  logic [DATA_W-1:0] conv_temp,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              therm_a_n,
  output logic              therm_b_n,
  output logic [DATA_W-1:0] dac_code,
  output logic              fan_off_n,
  output logic              locked,
  output logic [DATA_W-1:0] lim_int_q,
  output logic [DATA_W-1:0] lim_rem_q
);
  localparam logic [NCH*DATA_W-1:0] DEF_PACK = {DATA_W'(DEF_LIM_REM), DATA_W'(DEF_LIM_INT)};
  localparam logic [NCH*DATA_W-1:0] RST_PACK = {DATA_W'(RST_LIM_REM), DATA_W'(RST_LIM_INT)};

  logic [NCH*DATA_W-1:0] prog_lims, act_lims;
  logic [NCH-1:0]        chan_trip;
  logic                  trip_any;

  tg_limit_regs #(
    .DATA_W(DATA_W), .NLIM(NCH), .DEF_LIMS(DEF_PACK), .RST_LIMS(RST_PACK)
  ) u_lims (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .locked(locked), .prog_lims(prog_lims), .act_lims(act_lims)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = conv_valid && (conv_chan == 1'(g));
    tg_trip_chan #(.DATA_W(DATA_W), .QUAL_N(QUAL_N), .HYST(HYST)) u_trip (
      .clk(clk), .rst_n(rst_n), .sample_vld(hit), .sample(conv_temp),
      .limit(act_lims[g*DATA_W +: DATA_W]), .tripped(chan_trip[g])
    );
  end

  assign trip_any = |chan_trip;

  tg_fan_override #(.DATA_W(DATA_W)) u_fan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trip(trip_any), .dac_code(dac_code), .fan_off_n(fan_off_n)
  );

  assign conv_ready = 1'b1;
  assign therm_a_n  = ~trip_any;
  assign therm_b_n  = ~trip_any;
  assign lim_int_q  = prog_lims[CH_INT*DATA_W +: DATA_W];
  assign lim_rem_q  = prog_lims[CH_REM*DATA_W +: DATA_W];
endmodule

// File: rtl/therm_guard_chk.sv
module therm_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_valid,
  input logic              therm_a_n,
  input logic [DATA_W-1:0] dac_code,
  input logic              fan_off_n,
  input logic              locked,
  input logic [DATA_W-1:0] lim_int_q,
  input logic [DATA_W-1:0] lim_rem_q
);
  AST_FULL_SCALE_WHEN_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_a_n |-> dac_code == {DATA_W{1'b1}}); // R6
  AST_FAN_RELEASED_WHEN_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_a_n |-> fan_off_n); // R6
  AST_TRIP_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(therm_a_n) |-> $past(conv_valid)); // R2
  AST_CLEAR_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(therm_a_n) |-> $past(conv_valid)); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R5
  AST_LIMITS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> ($stable(lim_int_q) && $stable(lim_rem_q))); // R5
endmodule

bind therm_guard therm_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .therm_a_n(therm_a_n),
  .dac_code(dac_code), .fan_off_n(fan_off_n), .locked(locked),
  .lim_int_q(lim_int_q), .lim_rem_q(lim_rem_q)
);

// File: tb/therm_guard_tb.sv
module therm_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_valid = 1'b0;
  logic       conv_ready;
  logic       conv_chan = 1'b0;
  logic [7:0] conv_temp = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       therm_a_n, therm_b_n, fan_off_n, locked;
  logic [7:0] dac_code, lim_int_q, lim_rem_q;

  always #10 clk = ~clk;

  therm_guard u_dut (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_chan(conv_chan), .conv_temp(conv_temp), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .therm_a_n(therm_a_n), .therm_b_n(therm_b_n),
    .dac_code(dac_code), .fan_off_n(fan_off_n), .locked(locked),
    .lim_int_q(lim_int_q), .lim_rem_q(lim_rem_q)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";

  // Reference state built from the requirements.
  int m_cnt [2];
  bit m_trip[2];
  bit m_lock;
  int m_plim[2];
  int m_code;
  bit m_run;

  function automatic int act_lim(int ch);
    if (m_lock) return m_plim[ch];
    return (ch == 0) ? 70 : 100;
  endfunction

  task automatic model_reset();
    m_cnt[0] = 0; m_cnt[1] = 0; m_trip[0] = 0; m_trip[1] = 0;
    m_lock = 0; m_plim[0] = 127; m_plim[1] = 100; m_code = 0; m_run = 1;
  endtask

  task automatic model_conv(int ch, int t);
    int lim, thr;
    bit q;
    lim = act_lim(ch);
    thr = lim - 5;
    if (thr < -128) thr = -128;
    q = m_trip[ch] ? (t <= thr) : (t > lim);
    if (q) begin
      m_cnt[ch]++;
      if (m_cnt[ch] == 3) begin
        m_cnt[ch] = 0;
        m_trip[ch] = !m_trip[ch];
      end
    end else begin
      m_cnt[ch] = 0;
    end
  endtask

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit hot;
    hot = m_trip[0] | m_trip[1];
    check("conv_ready", int'(conv_ready), 1);
    check("therm_a_n", int'(therm_a_n), int'(!hot));
    check("therm_b_n", int'(therm_b_n), int'(!hot));
    check("dac_code", int'(dac_code), hot ? 255 : m_code);
    check("fan_off_n", int'(fan_off_n), hot ? 1 : int'(m_run));
    check("locked", int'(locked), int'(m_lock));
    check("lim_int_q", int'($signed(lim_int_q)), m_plim[0]);
    check("lim_rem_q", int'($signed(lim_rem_q)), m_plim[1]);
  endtask

  task automatic conv(int ch, int t);
    @(negedge clk);
    conv_valid = 1'b1; conv_chan = 1'(ch); conv_temp = 8'(t);
    @(negedge clk);
    conv_valid = 1'b0;
    model_conv(ch, t);
    check_all();
  endtask

  task automatic conv3(int ch, int t);
    for (int i = 0; i < 3; i++) conv(ch, t);
  endtask

  task automatic wr(int a, int d);
    int d8;
    d8 = d & 255;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(a); wr_data = 8'(d8);
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0, 1: if (!m_lock) m_plim[a] = (d8 > 127) ? d8 - 256 : d8;
      2:    if (d8[0]) m_lock = 1;
      3:    m_code = d8;
      4:    m_run = d8[0];
      default: ;
    endcase
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  task automatic sweep();
    for (int ch = 0; ch < 2; ch++) begin
      for (int t = -128; t < 128; t++) begin
        wr(3, t + 128);
        wr(4, t & 1);
        conv3(ch, t);
        conv3(ch, -128);
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    phase = "R1";
    do_reset();

    // Default limits across every reading; prog limits differ to prove they are ignored.
    phase = "R4";
    wr(0, 10);
    wr(1, 20);
    sweep();

    // Broken entry run: reading equal to limit restarts the count.
    phase = "R2";
    conv(0, 80); conv(0, 80); conv(0, 70); conv(0, 80); conv(0, 80);
    check("still cool after broken run", int'(therm_a_n), 1);
    conv(0, 80);
    check("tripped on third", int'(therm_a_n), 0);

    // Broken exit run: threshold is 65 for the internal default.
    phase = "R3";
    conv(0, 65); conv(0, 65); conv(0, 66); conv(0, 65); conv(0, 65);
    check("still hot after broken exit", int'(therm_a_n), 0);
    conv(0, 65);
    check("cleared on third", int'(therm_a_n), 1);

    // Interleaved channels keep separate counts; OR of the two states.
    phase = "R8";
    conv(0, 71); conv(1, 101); conv(0, 71); conv(1, 101); conv(0, 71);
    check("internal tripped through interleave", int'(therm_a_n), 0);
    conv(1, 101);
    conv3(0, -128);
    check("remote alone holds trip", int'(therm_b_n), 0);
    conv3(1, 0);
    check("both clear", int'(therm_b_n), 1);

    // Fan state written during trip is restored on exit.
    phase = "R7";
    wr(3, 8'h5A); wr(4, 1);
    conv3(1, 127);
    phase = "R6";
    check("dac forced full", int'(dac_code), 255);
    phase = "R7";
    wr(3, 8'h33); wr(4, 0);
    check("run bit masked while hot", int'(fan_off_n), 1);
    conv3(1, 95);
    check("code restored", int'(dac_code), 8'h33);
    check("run bit restored", int'(fan_off_n), 0);

    // Lock: bit 0 clear does nothing, then lock, then limit writes ignored.
    phase = "R5";
    wr(2, 8'hFE);
    check("lock ignored without bit0", int'(locked), 0);
    wr(0, -125);
    wr(1, 50);
    wr(2, 1);
    wr(0, 10);
    wr(1, 10);
    wr(2, 0);
    check("lock sticky", int'(locked), 1);
    check("int limit frozen", int'($signed(lim_int_q)), -125);

    // Locked remote limit 50 is now in force.
    phase = "R4";
    conv3(1, 60);
    check("prog remote limit active", int'(therm_a_n), 0);
    conv3(1, 45);

    // Saturated exit threshold with internal limit -125.
    phase = "R9";
    conv3(0, -120);
    conv3(0, -127);
    check("-127 does not clear", int'(therm_a_n), 0);
    conv3(0, -128);
    check("-128 clears", int'(therm_a_n), 1);

    phase = "R5";
    sweep();

    phase = "R1";
    do_reset();
    finish_run();
  end
endmodule